// File: doc/BRIEF.md
# Flat-Panel Serial Link Pixel Packer

This block sits in front of a single-link flat-panel serial transmitter. On every pixel clock it accepts one RGB pixel of up to ten bits per component. With the pixel come horizontal sync, vertical sync, a data-enable and two user control bits. One clock later it presents the pixel as a set of 7-bit lane words, ready for a downstream 7:1 serializer. It also drives a lane-enable mask and the fixed 7-bit pattern for the clock lane.

Configuration inputs set the colour depth (6, 8 or 10 bits per component, so 3, 4 or 5 data lanes), the level that marks active video on the data-enable input, the source of each user control bit, and which of two conventions places colour bits onto the lanes. In the high-order-low convention, the most significant bits of every component go on the first three lanes and the extra low-order bits of deeper formats go on the added lanes. In the low-order-low convention, the least significant active bits fill the first three lanes and the top bits move out to the added lanes. The serializer, the PLL and the analog drivers sit outside this block.

Top module: `lvds_pixel_packer`

## Requirements
- R1: While `rst_n` is low at a clock edge, all lane words become zero, `lane_en` becomes 5'b00000 and `clk_lane` becomes 7'b1100011.
- R2: Every output reflects the inputs sampled at the previous rising edge: exactly one clock of latency, with no change between edges.
- R3: `cfg_depth` 0 selects 6 bits/component (`lane_en`=00111), 1 selects 8 (01111), 2 selects 10 (11111), and 3 behaves as 0. A disabled lane carries 7'b0000000.
- R4: Truncation keeps the top bits of each 10-bit component: bits [9:4] at 6 bits/component and [9:2] at 8 bits/component. The dropped low bits have no effect on any output.
- R5: With `cfg_map`=0, core6 = c[9:4] for each component. At 8 bits the first extension pair (ext3) is c[3:2]. At 10 bits ext3 = c[3:2] and the second pair (ext4) is c[1:0].
- R6: With `cfg_map`=1, at 6 bits core6 = c[9:4]. At 8 bits core6 = c[7:2] and ext3 = c[9:8]. At 10 bits core6 = c[5:0], ext3 = c[7:6] and ext4 = c[9:8].
- R7: Lane word n sits at `lane_data[7n+6:7n]`. Lane 0 holds R core6[5:0] in bits 0-5 and G core6[0] in bit 6. Lane 1 holds G core6[5:1] in bits 0-4 and B core6[1:0] in bits 5-6. Lane 2 holds B core6[5:2] in bits 0-3, HS in bit 4 and VS in bit 5. Lanes 3 and 4 hold the R, G and B extension pairs (ext3 and ext4 respectively) in bits 0-1, 2-3 and 4-5.
- R8: Lane 2 bit 6 carries data-enable normalised to active-high. It is 1 when `de` equals `cfg_de_pol`, where `cfg_de_pol`=1 means a high level marks active video.
- R9: Each user bit select means 0: constant 0, 1: constant 1, 2: the input pin, 3: the inverted pin. The first user bit goes to lane 3 bit 6 and the second to lane 4 bit 6.
- R10: After reset, `clk_lane` stays at 7'b1100011 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_r | input | 10 | Red component, MSB-aligned |
| pix_g | input | 10 | Green component, MSB-aligned |
| pix_b | input | 10 | Blue component, MSB-aligned |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data-enable, polarity per `cfg_de_pol` |
| usr_a | input | 1 | First user control pin |
| usr_b | input | 1 | Second user control pin |
| cfg_depth | input | 2 | Colour depth code |
| cfg_map | input | 1 | Lane mapping convention |
| cfg_de_pol | input | 1 | 1: DE active high, 0: active low |
| cfg_usr_a_sel | input | 2 | Source select for first user bit |
| cfg_usr_b_sel | input | 2 | Source select for second user bit |
| lane_data | output | 35 | Five 7-bit lane words, lane 0 lowest |
| lane_en | output | 5 | Per-lane enable mask |
| clk_lane | output | 7 | Clock lane pattern |

## Verification
The bench changes the low component bits while the high bits stay fixed and expects identical lanes at 6 and 8 bits per component. A design that truncates from the wrong end would let noise leak into the lanes. Every depth is crossed with both mapping conventions, so a swapped extension pair or a core slice taken from the wrong offset shows up as misplaced colour bits. Depth code 3 and the disabled lanes are checked for zero words and a cleared enable, which catches stale data on lanes 3 and 4. Both polarities and all four select codes are driven on the control bits, which catches an inverted DE or an off-by-one select. A mid-cycle sample catches an output that bypasses the register.

// File: rtl/lvds_pack_pkg.sv
// Shared constants and encodings for the flat-panel pixel packer.
// Assumes components arrive MSB-aligned in a 10-bit field.
package lvds_pack_pkg;
    localparam int COMP_W     = 10;
    localparam int CORE_W     = 6;
    localparam int EXT_W      = 2;
    localparam int LANE_W     = 7;
    localparam int NUM_LANES  = 5;
    localparam int NUM_COMP   = 3;
    localparam logic [LANE_W-1:0] CLK_PATTERN = 7'b1100011;

    typedef enum logic [1:0] {
        DEPTH_6  = 2'd0,
        DEPTH_8  = 2'd1,
        DEPTH_10 = 2'd2,
        DEPTH_RSV = 2'd3
    } depth_e;

    typedef enum logic {
        MAP_HI_LOW = 1'b0,
        MAP_LO_LOW = 1'b1
    } map_e;

    typedef enum logic [1:0] {
        USR_ZERO    = 2'd0,
        USR_ONE     = 2'd1,
        USR_PIN     = 2'd2,
        USR_PIN_INV = 2'd3
    } usr_sel_e;

    // Lane enable mask for a given depth code; reserved code acts as 6-bit.
    function automatic logic [NUM_LANES-1:0] lanes_for(input logic [1:0] d);
        case (d)
            DEPTH_8:  return 5'b01111;
            DEPTH_10: return 5'b11111;
            default:  return 5'b00111;
        endcase
    endfunction
endpackage

// File: rtl/lvds_comp_slicer.sv
// Splits one MSB-aligned component into a 6-bit core slice and two 2-bit
// extension pairs according to depth and mapping convention.
// Assumes COMP_W is 10 (6/8/10 bit depths). Combinational.
module lvds_comp_slicer
    import lvds_pack_pkg::*;
#(
    parameter int CW = COMP_W
) (
    input  logic [CW-1:0]     comp,
    input  logic [1:0]        depth,
    input  logic              map_sel,
    output logic [CORE_W-1:0] core,
    output logic [EXT_W-1:0]  ext3,
    output logic [EXT_W-1:0]  ext4
);
    localparam int TOP = CW - 1;

    // Choose core and extension bits for the active convention and depth.
    always_comb begin
        core = comp[TOP -: CORE_W];
        ext3 = '0;
        ext4 = '0;
        if (map_sel == MAP_HI_LOW) begin
            if (depth == DEPTH_8 || depth == DEPTH_10)
                ext3 = comp[TOP-CORE_W -: EXT_W];
            if (depth == DEPTH_10)
                ext4 = comp[TOP-CORE_W-EXT_W -: EXT_W];
        end else begin
            case (depth)
                DEPTH_8: begin
                    core = comp[TOP-EXT_W -: CORE_W];
                    ext3 = comp[TOP -: EXT_W];
                end
                DEPTH_10: begin
                    core = comp[TOP-2*EXT_W -: CORE_W];
                    ext3 = comp[TOP-EXT_W -: EXT_W];
                    ext4 = comp[TOP -: EXT_W];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lvds_ctrl_select.sv
// Normalises data-enable to active-high and resolves the two user control
// bits from their 2-bit source selects. Combinational.
module lvds_ctrl_select
    import lvds_pack_pkg::*;
#(
    parameter int NUM_USR = 2
) (
    input  logic                 de_in,
    input  logic                 de_pol,
    input  logic [NUM_USR-1:0]   usr_pin,
    input  logic [2*NUM_USR-1:0] usr_sel,
    output logic                 de_act,
    output logic [NUM_USR-1:0]   usr_bit
);
    // Active when the pin level matches the programmed active level.
    always_comb de_act = (de_in == de_pol);

    for (genvar u = 0; u < NUM_USR; u++) begin : g_usr
        // Pick one of four sources for this user bit.
        always_comb begin
            case (usr_sel[2*u +: 2])
                USR_ZERO:    usr_bit[u] = 1'b0;
                USR_ONE:     usr_bit[u] = 1'b1;
                USR_PIN:     usr_bit[u] = usr_pin[u];
                default:     usr_bit[u] = ~usr_pin[u];
            endcase
        end
    end
endmodule

// File: rtl/lvds_lane_assemble.sv
// Places component slices, sync, data-enable and user bits into five
// 7-bit lane words and derives the lane-enable mask. Combinational.
module lvds_lane_assemble
    import lvds_pack_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = NUM_LANES
) (
    input  logic [NUM_COMP*CORE_W-1:0] core_all,
    input  logic [NUM_COMP*EXT_W-1:0]  ext3_all,
    input  logic [NUM_COMP*EXT_W-1:0]  ext4_all,
    input  logic                       hs,
    input  logic                       vs,
    input  logic                       de_act,
    input  logic [1:0]                 usr_bit,
    input  logic [1:0]                 depth,
    output logic [NL*LW-1:0]           lanes,
    output logic [NL-1:0]              lane_mask
);
    localparam int CORE_ALL = NUM_COMP * CORE_W;

    // Core bits stream across lanes 0..2, controls fill the top of lane 2.
    always_comb begin
        lanes = '0;
        lanes[CORE_ALL-1:0]         = core_all;
        lanes[2*LW+4]               = hs;
        lanes[2*LW+5]               = vs;
        lanes[2*LW+6]               = de_act;
        lanes[3*LW +: NUM_COMP*EXT_W] = ext3_all;
        lanes[3*LW+6]               = usr_bit[0];
        lanes[4*LW +: NUM_COMP*EXT_W] = ext4_all;
        lanes[4*LW+6]               = usr_bit[1];
    end

    // Lane count follows the colour depth.
    always_comb lane_mask = lanes_for(depth);
endmodule

// File: rtl/lvds_lane_reg.sv
// Output register stage: one clock of latency, disabled lanes forced to
// zero, clock lane held at its fixed pattern. Synchronous active-low reset.
module lvds_lane_reg
    import lvds_pack_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = NUM_LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NL*LW-1:0] lanes_d,
    input  logic [NL-1:0]    mask_d,
    output logic [NL*LW-1:0] lanes_q,
    output logic [NL-1:0]    mask_q,
    output logic [LW-1:0]    clk_q
);
    for (genvar l = 0; l < NL; l++) begin : g_lane
        // Register one lane word, zero when the lane is off.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lanes_q[l*LW +: LW] <= '0;
                mask_q[l]           <= 1'b0;
            end else begin
                lanes_q[l*LW +: LW] <= mask_d[l] ? lanes_d[l*LW +: LW] : '0;
                mask_q[l]           <= mask_d[l];
            end
        end
    end

    // Clock lane pattern, reloaded on every edge.
    always_ff @(posedge clk) begin
        clk_q <= CLK_PATTERN;
    end
endmodule

// File: rtl/lvds_pixel_packer.sv
// Top of the flat-panel pixel packer. Takes one pixel per clock and emits
// five 7-bit lane words one clock later. Assumes a single pixel clock and
// that configuration inputs are quasi-static relative to the pixel stream.
module lvds_pixel_packer
    import lvds_pack_pkg::*;
#(
    parameter int CW = COMP_W,
    parameter int LW = LANE_W,
    parameter int NL = NUM_LANES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    pix_r,
    input  logic [CW-1:0]    pix_g,
    input  logic [CW-1:0]    pix_b,
    input  logic             pix_hs,
    input  logic             pix_vs,
    input  logic             pix_de,
    input  logic             usr_a,
    input  logic             usr_b,
    input  logic [1:0]       cfg_depth,
    input  logic             cfg_map,
    input  logic             cfg_de_pol,
    input  logic [1:0]       cfg_usr_a_sel,
    input  logic [1:0]       cfg_usr_b_sel,
    output logic [NL*LW-1:0] lane_data,
    output logic [NL-1:0]    lane_en,
    output logic [LW-1:0]    clk_lane
);
    logic [NUM_COMP*CW-1:0]     comp_all;
    logic [NUM_COMP*CORE_W-1:0] core_all;
    logic [NUM_COMP*EXT_W-1:0]  ext3_all;
    logic [NUM_COMP*EXT_W-1:0]  ext4_all;
    logic                       de_act;
    logic [1:0]                 usr_bit;
    logic [NL*LW-1:0]           lanes_d;
    logic [NL-1:0]              mask_d;

    // Gather components in lane order: red first.
    always_comb comp_all = {pix_b, pix_g, pix_r};

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
        lvds_comp_slicer #(.CW(CW)) i_slice (
            .comp    (comp_all[c*CW +: CW]),
            .depth   (cfg_depth),
            .map_sel (cfg_map),
            .core    (core_all[c*CORE_W +: CORE_W]),
            .ext3    (ext3_all[c*EXT_W +: EXT_W]),
            .ext4    (ext4_all[c*EXT_W +: EXT_W])
        );
    end

    lvds_ctrl_select #(.NUM_USR(2)) i_ctrl (
        .de_in   (pix_de),
        .de_pol  (cfg_de_pol),
        .usr_pin ({usr_b, usr_a}),
        .usr_sel ({cfg_usr_b_sel, cfg_usr_a_sel}),
        .de_act  (de_act),
        .usr_bit (usr_bit)
    );

    lvds_lane_assemble #(.LW(LW), .NL(NL)) i_asm (
        .core_all  (core_all),
        .ext3_all  (ext3_all),
        .ext4_all  (ext4_all),
        .hs        (pix_hs),
        .vs        (pix_vs),
        .de_act    (de_act),
        .usr_bit   (usr_bit),
        .depth     (cfg_depth),
        .lanes     (lanes_d),
        .lane_mask (mask_d)
    );

    lvds_lane_reg #(.LW(LW), .NL(NL)) i_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lanes_d (lanes_d),
        .mask_d  (mask_d),
        .lanes_q (lane_data),
        .mask_q  (lane_en),
        .clk_q   (clk_lane)
    );
endmodule

// File: rtl/lvds_pack_checker.sv
// Port-level properties of the pixel packer, bound to every instance.
module lvds_pack_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pix_hs,
    input logic        pix_vs,
    input logic        pix_de,
    input logic [1:0]  cfg_depth,
    input logic        cfg_de_pol,
    input logic [34:0] lane_data,
    input logic [4:0]  lane_en,
    input logic [6:0]  clk_lane
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (lane_en == 5'b0 && lane_data == 35'b0 && clk_lane == 7'b1100011)); // R1

    AST_CLK_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> clk_lane == 7'b1100011); // R10

    AST_EN_FOLLOWS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lane_en == (($past(cfg_depth) == 2'd2) ? 5'b11111 :
                             ($past(cfg_depth) == 2'd1) ? 5'b01111 : 5'b00111)); // R3

    AST_LANE3_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_en[3] |-> lane_data[27:21] == 7'b0); // R3

    AST_LANE4_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_en[4] |-> lane_data[34:28] == 7'b0); // R3

    AST_SYNC_PLACED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lane_data[19:18] == {$past(pix_vs), $past(pix_hs)}); // R7

    AST_DE_NORMALISED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lane_data[20] == ($past(pix_de) == $past(cfg_de_pol))); // R8

    AST_EN_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lane_en + 5'd1)); // R3
endmodule

bind lvds_pixel_packer lvds_pack_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_hs     (pix_hs),
    .pix_vs     (pix_vs),
    .pix_de     (pix_de),
    .cfg_depth  (cfg_depth),
    .cfg_de_pol (cfg_de_pol),
    .lane_data  (lane_data),
    .lane_en    (lane_en),
    .clk_lane   (clk_lane)
);

// File: tb/test_lvds_pixel_packer.sv
module test_lvds_pixel_packer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  pix_r, pix_g, pix_b;
    logic        pix_hs, pix_vs, pix_de, usr_a, usr_b;
    logic [1:0]  cfg_depth, cfg_usr_a_sel, cfg_usr_b_sel;
    logic        cfg_map, cfg_de_pol;
    logic [34:0] lane_data;
    logic [4:0]  lane_en;
    logic [6:0]  clk_lane;

    int checks = 0;
    int fails  = 0;
    logic [34:0] prev_lanes;

    always #4 clk = ~clk;

    lvds_pixel_packer i_lvds_pixel_packer (
        .clk(clk), .rst_n(rst_n), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
        .usr_a(usr_a), .usr_b(usr_b), .cfg_depth(cfg_depth), .cfg_map(cfg_map),
        .cfg_de_pol(cfg_de_pol), .cfg_usr_a_sel(cfg_usr_a_sel),
        .cfg_usr_b_sel(cfg_usr_b_sel), .lane_data(lane_data),
        .lane_en(lane_en), .clk_lane(clk_lane)
    );

    function automatic logic [4:0] exp_en(input logic [1:0] d);
        if (d == 2'd1) return 5'b01111;
        if (d == 2'd2) return 5'b11111;
        return 5'b00111;
    endfunction

    function automatic logic usr_val(input logic [1:0] s, input logic pin);
        case (s)
            2'd0: return 1'b0;
            2'd1: return 1'b1;
            2'd2: return pin;
            default: return !pin;
        endcase
    endfunction

    // Slice one component per R4/R5/R6 into {ext4, ext3, core6}.
    function automatic logic [9:0] slice(input logic [9:0] c, input logic [1:0] d,
                                         input logic m);
        logic [5:0] core;
        logic [1:0] e3, e4;
        core = c[9:4]; e3 = 2'b0; e4 = 2'b0;
        if (d == 2'd1) begin
            if (m) begin core = c[7:2]; e3 = c[9:8]; end
            else   e3 = c[3:2];
        end else if (d == 2'd2) begin
            if (m) begin core = c[5:0]; e3 = c[7:6]; e4 = c[9:8]; end
            else   begin e3 = c[3:2]; e4 = c[1:0]; end
        end
        return {e4, e3, core};
    endfunction

    // Expected lane vector per R7/R8/R9 with lanes masked per R3.
    function automatic logic [34:0] exp_lanes(
        input logic [9:0] r, input logic [9:0] g, input logic [9:0] b,
        input logic hs, input logic vs, input logic de, input logic ua,
        input logic ub, input logic [1:0] d, input logic m, input logic pol,
        input logic [1:0] sa, input logic [1:0] sb);
        logic [9:0] sr, sg, sbl;
        logic [6:0] l0, l1, l2, l3, l4;
        logic [4:0] en;
        sr = slice(r, d, m); sg = slice(g, d, m); sbl = slice(b, d, m);
        l0 = {sg[0], sr[5:0]};
        l1 = {sbl[1:0], sg[5:1]};
        l2 = {(de == pol), vs, hs, sbl[5:2]};
        l3 = {usr_val(sa, ua), sbl[7:6], sg[7:6], sr[7:6]};
        l4 = {usr_val(sb, ub), sbl[9:8], sg[9:8], sr[9:8]};
        en = exp_en(d);
        if (!en[3]) l3 = 7'b0;
        if (!en[4]) l4 = 7'b0;
        return {l4, l3, l2, l1, l0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [34:0] cur_exp();
        return exp_lanes(pix_r, pix_g, pix_b, pix_hs, pix_vs, pix_de, usr_a, usr_b,
                         cfg_depth, cfg_map, cfg_de_pol, cfg_usr_a_sel, cfg_usr_b_sel);
    endfunction

    // Apply current inputs for one edge and check the result at the next low phase.
    task automatic step(input string req);
        logic [34:0] e;
        logic [4:0]  en;
        e  = cur_exp();
        en = exp_en(cfg_depth);
        @(posedge clk);
        @(negedge clk);
        check(req, {29'b0, lane_data}, {29'b0, e});
        check("R3 lane_en", {59'b0, lane_en}, {59'b0, en});
    endtask

    task automatic set_pix(input logic [9:0] r, input logic [9:0] g, input logic [9:0] b);
        pix_r = r; pix_g = g; pix_b = b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        set_pix(10'h3FF, 10'h3FF, 10'h3FF);
        pix_hs = 1; pix_vs = 1; pix_de = 1; usr_a = 1; usr_b = 1;
        cfg_depth = 2'd2; cfg_map = 0; cfg_de_pol = 1;
        cfg_usr_a_sel = 2'd1; cfg_usr_b_sel = 2'd1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 lanes", {29'b0, lane_data}, 64'd0);
        check("R1 lane_en", {59'b0, lane_en}, 64'd0);
        check("R1 clk_lane", {57'b0, clk_lane}, {57'b0, 7'b1100011});
        rst_n = 1'b1;

        // R5: high-order-low mapping at each depth with a distinct pattern
        for (int d = 0; d < 3; d++) begin
            cfg_depth = d[1:0]; cfg_map = 0;
            set_pix(10'h2B5, 10'h1C6, 10'h339);
            step("R5 map hi-low");
        end
        // R6: low-order-low mapping at each depth
        for (int d = 0; d < 3; d++) begin
            cfg_depth = d[1:0]; cfg_map = 1;
            set_pix(10'h2B5, 10'h1C6, 10'h339);
            step("R6 map lo-low");
        end
        // R7: walking single bit through red in 10-bit low-order-low mode
        cfg_depth = 2'd2; cfg_map = 1;
        for (int i = 0; i < 10; i++) begin
            set_pix(10'd1 << i, 10'd0, 10'd0);
            step("R7 bit position");
        end

        // R4: low bits ignored at 6 and 8 bits/component
        for (int d = 0; d < 2; d++) begin
            cfg_depth = d[1:0]; cfg_map = 0;
            set_pix(10'h2A0, 10'h150, 10'h3F0);
            step("R4 base");
            prev_lanes = lane_data;
            pix_r = pix_r | (d == 0 ? 10'h00F : 10'h003);
            pix_g = pix_g | (d == 0 ? 10'h00A : 10'h002);
            pix_b = pix_b | (d == 0 ? 10'h005 : 10'h001);
            @(posedge clk); @(negedge clk);
            check("R4 truncated bits ignored", {29'b0, lane_data}, {29'b0, prev_lanes});
        end

        // R3: reserved depth acts as 6 bits/component with lanes 3,4 zero
        cfg_depth = 2'd3; cfg_map = 1;
        cfg_usr_a_sel = 2'd1; cfg_usr_b_sel = 2'd1;
        set_pix(10'h3FF, 10'h3FF, 10'h3FF);
        step("R3 reserved depth");

        // R8: both DE polarities and both pin levels
        cfg_depth = 2'd2;
        for (int p = 0; p < 2; p++) begin
            for (int v = 0; v < 2; v++) begin
                cfg_de_pol = p[0]; pix_de = v[0];
                step("R8 de polarity");
            end
        end

        // R9: all select codes with both pin levels
        for (int s = 0; s < 4; s++) begin
            for (int v = 0; v < 2; v++) begin
                cfg_usr_a_sel = s[1:0]; cfg_usr_b_sel = 2'(3 - s);
                usr_a = v[0]; usr_b = !v[0];
                step("R9 user select");
            end
        end

        // R2: output holds between edges, then updates one edge later
        prev_lanes = lane_data;
        set_pix(~pix_r, ~pix_g, ~pix_b);
        pix_hs = !pix_hs;
        #1;
        check("R2 no early change", {29'b0, lane_data}, {29'b0, prev_lanes});
        step("R2 one-clock latency");

        // Random traffic across all configurations
        for (int n = 0; n < 400; n++) begin
            set_pix(10'($urandom), 10'($urandom), 10'($urandom));
            {pix_hs, pix_vs, pix_de, usr_a, usr_b} = 5'($urandom);
            cfg_depth = 2'($urandom); cfg_map = 1'($urandom);
            cfg_de_pol = 1'($urandom);
            cfg_usr_a_sel = 2'($urandom); cfg_usr_b_sel = 2'($urandom);
            step("R7 random pack");
            check("R10 clk_lane", {57'b0, clk_lane}, {57'b0, 7'b1100011});
        end

        // R1: reset again mid-stream
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 re-reset lanes", {29'b0, lane_data}, 64'd0);
        check("R1 re-reset lane_en", {59'b0, lane_en}, 64'd0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule